// File: doc/BRIEF.md
# Descriptor-List Audio Stream DMA Engine

This block is the DMA engine of a single audio stream. Software places a list of buffer descriptors in memory. Each descriptor gives a start address, a byte length and an interrupt-on-completion flag. Software then sets the run bit in the stream's control word. The engine reads the whole list into a local descriptor table. After that it serves transfer requests from a codec. Each request carries a stream tag and a byte count.

The engine splits each accepted request into memory chunks. A chunk never crosses the end of the current descriptor or the end of the cyclic buffer. For each chunk the engine issues one memory request, then advances its link position, entry index and in-entry offset. When a flagged descriptor runs out, the engine raises a sticky completion bit. While that bit is set, further requests are refused. When enabled, the engine reports its link position to a position buffer in memory after every request.

Sample formatting and the data path itself lie outside the block. A memory request names an address, a length and a direction, and the data moves elsewhere.

Top module: `bdl_dma_engine`

## Requirements
- R1: After reset the control word reads 0, the link position reads 0, no memory request is raised and the transfer port is ready.
- R2: A control write stores the written value in bits 4:0 and 23:16 only. Bits 28:26 are status bits: writing 1 clears them and writing 0 leaves them unchanged. Every other bit reads 0.
- R3: A control write with bit 0 set leaves the entire control word at zero.
- R4: A 0-to-1 change of control bit 1 (run) fetches entries 0 through the last-valid index, in order. Each fetch is a 16-byte read at list base + 16 × index. The read response carries the address in bits 63:0, the length in bits 95:64 and the completion flag in bit 96. Loading also zeroes the link position, entry index and offset, and captures the buffer size from the cyclic-length register.
- R5: A transfer is accepted only if all of these hold: run is set, a list has been loaded, control bits 23:20 equal the request tag, and bit 26 is clear. Any other request ends with `xfer_ok` = 0 and issues no memory request. The link position does not change.
- R6: Each chunk length is the smallest of three values: the bytes left in the request, the buffer size minus the link position, and the descriptor length minus the in-entry offset. The chunk address is the descriptor address plus the offset, and the direction bit equals the CAPTURE parameter.
- R7: Consuming the last byte of a descriptor moves the engine to the next entry with offset 0. After the last-valid entry it returns to entry 0 and sets the link position to 0.
- R8: A link position that reaches the buffer size wraps to 0 without changing the entry or the offset.
- R9: If any descriptor whose completion flag is set was consumed during a request, control bit 26 is set when that request completes.
- R10: If bit 0 of the position-buffer base is set, each accepted request ends with a 4-byte write of the link position. The write goes to the base with bit 0 cleared, plus 8 × STREAM_IDX, and follows the last chunk. Otherwise no position write occurs.
- R11: A memory request holds its kind, address and length until `mem_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 control, 1 cyclic length, 2 last-valid index, 3/4 list base low/high (low 7 bits forced 0), 5/6 position base low/high (bit 0 enables) |
| reg_wdata | input | 32 | Register write data |
| ctl_q | output | 32 | Current control word |
| link_pos | output | 32 | Current link position in bytes |
| xfer_ready | output | 1 | Engine idle, able to take a transfer request |
| xfer_start | input | 1 | One-cycle transfer request |
| xfer_tag | input | 4 | Stream tag of the request |
| xfer_bytes | input | 32 | Byte count of the request |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_ok | output | 1 | With xfer_done: 1 served, 0 refused |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_kind | output | 2 | 0 descriptor read, 1 data chunk, 2 position write |
| mem_write | output | 1 | Request writes memory |
| mem_addr | output | 64 | Request byte address |
| mem_len | output | 32 | Request byte length |
| mem_wdata | output | 32 | Position value for a position write |
| mem_rvalid | input | 1 | Descriptor read data valid |
| mem_rdata | input | 128 | Descriptor read data |

## Verification
Wrong internal state shows up first on the memory port. A bad offset, entry index or buffer size gives the next data chunk the wrong address or length, and the next handshake exposes it. A bad link position is visible on `link_pos` and in the position write as soon as the request ends. A lost or stuck completion bit shows at `xfer_ok` on the very next request, which is wrongly served or wrongly refused. A fetch with the wrong layout or order gives the first chunk after loading the wrong address.

// File: rtl/bdl_dma_pkg.sv
package bdl_dma_pkg;

    localparam logic [31:0] CTL_WMASK   = 32'h00FF_001F;
    localparam logic [31:0] CTL_STATUS  = 32'h1C00_0000;
    localparam int          BIT_SRST    = 0;
    localparam int          BIT_RUN     = 1;
    localparam int          BIT_DONE    = 26;
    localparam int          TAG_LSB     = 20;
    localparam int          TAG_W       = 4;
    localparam int          DESC_BYTES  = 16;
    localparam logic [63:0] LIST_ALIGN  = 64'hFFFF_FFFF_FFFF_FF80;
    localparam logic [63:0] POS_ALIGN   = 64'hFFFF_FFFF_FFFF_FF81;

    typedef enum logic [2:0] {
        SEL_CTL     = 3'd0,
        SEL_CBL     = 3'd1,
        SEL_LVI     = 3'd2,
        SEL_LIST_LO = 3'd3,
        SEL_LIST_HI = 3'd4,
        SEL_POS_LO  = 3'd5,
        SEL_POS_HI  = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        KIND_DESC = 2'd0,
        KIND_DATA = 2'd1,
        KIND_POS  = 2'd2
    } mem_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_CHUNK,
        ST_POS,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        logic        ioc;
        logic [31:0] len;
        logic [63:0] addr;
    } desc_t;

    function automatic desc_t unpack_desc(input logic [127:0] raw);
        desc_t d;
        d.addr = raw[63:0];
        d.len  = raw[95:64];
        d.ioc  = raw[96];
        return d;
    endfunction

    function automatic logic [31:0] min3(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input logic [31:0] c);
        logic [31:0] m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

endpackage

// File: rtl/bdl_dma_regs.sv
module bdl_dma_regs
    import bdl_dma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  reg_sel_e         reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             set_done,
    output logic [31:0]      ctl,
    output logic [31:0]      cbl,
    output logic [IDX_W-1:0] lvi,
    output logic [63:0]      list_base,
    output logic [63:0]      pos_base,
    output logic             run_rise
);

    logic [31:0] ctl_nxt;
    logic        ctl_wr;

    assign ctl_wr = reg_we && (reg_sel == SEL_CTL);

    always_comb begin
        ctl_nxt = ctl;
        if (ctl_wr) begin
            ctl_nxt = (ctl & ~CTL_WMASK) | (reg_wdata & CTL_WMASK);
            ctl_nxt = ctl_nxt & ~(reg_wdata & CTL_STATUS);
        end
        if (set_done) ctl_nxt[BIT_DONE] = 1'b1;
        if (ctl_wr && reg_wdata[BIT_SRST]) ctl_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            cbl       <= '0;
            lvi       <= '0;
            list_base <= '0;
            pos_base  <= '0;
            run_rise  <= 1'b0;
        end else begin
            ctl      <= ctl_nxt;
            run_rise <= !ctl[BIT_RUN] && ctl_nxt[BIT_RUN];
            if (reg_we) begin
                case (reg_sel)
                    SEL_CBL:     cbl             <= reg_wdata;
                    SEL_LVI:     lvi             <= reg_wdata[IDX_W-1:0];
                    SEL_LIST_LO: list_base[31:0]  <= reg_wdata & LIST_ALIGN[31:0];
                    SEL_LIST_HI: list_base[63:32] <= reg_wdata;
                    SEL_POS_LO:  pos_base[31:0]   <= reg_wdata & POS_ALIGN[31:0];
                    SEL_POS_HI:  pos_base[63:32]  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !reg_wdata[BIT_DONE] && !reg_wdata[BIT_SRST] && ctl[BIT_DONE])
        |=> ctl[BIT_DONE]);

    // R3
    srst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && reg_wdata[BIT_SRST]) |=> (ctl == 32'd0));

endmodule

// File: rtl/bdl_dma_table.sv
module bdl_dma_table
    import bdl_dma_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);

    desc_t entries [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) entries[wr_idx] <= wr_desc;
    end

    assign rd_desc = entries[rd_idx];

endmodule

// File: rtl/bdl_dma_chunk.sv
module bdl_dma_chunk
    import bdl_dma_pkg::*;
(
    input  logic [31:0] left,
    input  logic [31:0] bsize,
    input  logic [31:0] lpib,
    input  logic [31:0] dlen,
    input  logic [31:0] offset,
    output logic [31:0] chunk,
    output logic        ends_desc,
    output logic        ends_buf
);

    logic [31:0] room_buf;
    logic [31:0] room_desc;

    always_comb begin
        room_buf  = bsize - lpib;
        room_desc = dlen - offset;
        chunk     = min3(left, room_buf, room_desc);
        ends_desc = (offset + chunk) == dlen;
        ends_buf  = (lpib + chunk) == bsize;
    end

endmodule

// File: rtl/bdl_dma_engine.sv
module bdl_dma_engine
    import bdl_dma_pkg::*;
#(
    parameter int MAX_ENTRIES = 256,
    parameter int STREAM_IDX  = 0,
    parameter bit CAPTURE     = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_we,
    input  logic [2:0]   reg_sel,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  ctl_q,
    output logic [31:0]  link_pos,
    output logic         xfer_ready,
    input  logic         xfer_start,
    input  logic [3:0]   xfer_tag,
    input  logic [31:0]  xfer_bytes,
    output logic         xfer_done,
    output logic         xfer_ok,
    output logic         mem_valid,
    input  logic         mem_ready,
    output logic [1:0]   mem_kind,
    output logic         mem_write,
    output logic [63:0]  mem_addr,
    output logic [31:0]  mem_len,
    output logic [31:0]  mem_wdata,
    input  logic         mem_rvalid,
    input  logic [127:0] mem_rdata
);

    localparam int          IDX_W      = $clog2(MAX_ENTRIES);
    localparam logic [63:0] POS_OFFSET = 64'(STREAM_IDX) << 3;

    eng_state_e       state;
    logic [31:0]      ctl, cbl;
    logic [IDX_W-1:0] lvi, last_idx, fetch_idx, entry;
    logic [63:0]      list_base, pos_base;
    logic             run_rise, load_pend, loaded, irq_acc;
    logic [31:0]      lpib, offset, bsize, left;
    logic             done_q, ok_q, set_done;
    desc_t            cur_desc;
    logic [31:0]      chunk;
    logic             ends_desc, ends_buf, accept, start_load;
    logic [31:0]      lpib_step;

    bdl_dma_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel_e'(reg_sel)),
        .reg_wdata(reg_wdata), .set_done(set_done), .ctl(ctl), .cbl(cbl),
        .lvi(lvi), .list_base(list_base), .pos_base(pos_base), .run_rise(run_rise)
    );

    bdl_dma_table #(.DEPTH(MAX_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk(clk), .wr_en(state == ST_FETCH_WAIT && mem_rvalid),
        .wr_idx(fetch_idx), .wr_desc(unpack_desc(mem_rdata)),
        .rd_idx(entry), .rd_desc(cur_desc)
    );

    bdl_dma_chunk u_chunk (
        .left(left), .bsize(bsize), .lpib(lpib), .dlen(cur_desc.len),
        .offset(offset), .chunk(chunk), .ends_desc(ends_desc), .ends_buf(ends_buf)
    );

    assign ctl_q      = ctl;
    assign link_pos   = lpib;
    assign xfer_done  = done_q;
    assign xfer_ok    = ok_q;
    assign xfer_ready = (state == ST_IDLE) && !load_pend;
    assign set_done   = (state == ST_FINISH) && irq_acc;
    assign start_load = (state == ST_IDLE) && load_pend;
    assign accept     = ctl[BIT_RUN] && loaded && !ctl[BIT_DONE]
                        && (ctl[TAG_LSB +: TAG_W] == xfer_tag);
    assign lpib_step  = ends_buf ? 32'd0 : lpib + chunk;

    always_comb begin
        mem_valid = 1'b0;
        mem_kind  = KIND_DESC;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_len   = '0;
        mem_wdata = '0;
        case (state)
            ST_FETCH_REQ: begin
                mem_valid = 1'b1;
                mem_addr  = list_base + (64'(fetch_idx) << 4);
                mem_len   = 32'(DESC_BYTES);
            end
            ST_CHUNK: begin
                mem_valid = (left != 32'd0);
                mem_kind  = KIND_DATA;
                mem_write = CAPTURE;
                mem_addr  = cur_desc.addr + 64'(offset);
                mem_len   = chunk;
            end
            ST_POS: begin
                mem_valid = 1'b1;
                mem_kind  = KIND_POS;
                mem_write = 1'b1;
                mem_addr  = {pos_base[63:1], 1'b0} + POS_OFFSET;
                mem_len   = 32'd4;
                mem_wdata = lpib;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            load_pend <= 1'b0;
            loaded    <= 1'b0;
            fetch_idx <= '0;
            last_idx  <= '0;
            entry     <= '0;
            offset    <= '0;
            lpib      <= '0;
            bsize     <= '0;
            left      <= '0;
            irq_acc   <= 1'b0;
            done_q    <= 1'b0;
            ok_q      <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            load_pend <= run_rise || (load_pend && !start_load);
            case (state)
                ST_IDLE: begin
                    if (load_pend) begin
                        loaded    <= 1'b0;
                        fetch_idx <= '0;
                        last_idx  <= lvi;
                        entry     <= '0;
                        offset    <= '0;
                        lpib      <= '0;
                        bsize     <= cbl;
                        state     <= ST_FETCH_REQ;
                    end else if (xfer_start) begin
                        if (accept) begin
                            left    <= xfer_bytes;
                            irq_acc <= 1'b0;
                            state   <= ST_CHUNK;
                        end else begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b0;
                        end
                    end
                end
                ST_FETCH_REQ: if (mem_ready) state <= ST_FETCH_WAIT;
                ST_FETCH_WAIT: begin
                    if (mem_rvalid) begin
                        if (fetch_idx == last_idx) begin
                            loaded <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            fetch_idx <= fetch_idx + 1'b1;
                            state     <= ST_FETCH_REQ;
                        end
                    end
                end
                ST_CHUNK: begin
                    if (left == 32'd0) begin
                        state <= pos_base[0] ? ST_POS : ST_FINISH;
                    end else if (mem_ready) begin
                        left <= left - chunk;
                        if (ends_desc) begin
                            offset  <= '0;
                            irq_acc <= irq_acc | cur_desc.ioc;
                            if (entry == last_idx) begin
                                entry <= '0;
                                lpib  <= '0;
                            end else begin
                                entry <= entry + 1'b1;
                                lpib  <= lpib_step;
                            end
                        end else begin
                            offset <= offset + chunk;
                            lpib   <= lpib_step;
                        end
                    end
                end
                ST_POS: if (mem_ready) state <= ST_FINISH;
                ST_FINISH: begin
                    done_q <= 1'b1;
                    ok_q   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_len) && $stable(mem_kind)));

    // R6
    chunk_fit_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_kind == KIND_DATA) |-> (mem_len != 32'd0 && mem_len <= left));

    // R5
    refuse_still_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !xfer_ok) |-> $stable(link_pos));

    // R8
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded && state == ST_IDLE) |-> (lpib < bsize));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!mem_valid && ctl_q == 32'd0 && link_pos == 32'd0));

endmodule

// File: tb/bdl_dma_engine_test.sv
module bdl_dma_engine_test;
    import bdl_dma_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_sel = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  ctl_q, link_pos;
    logic         xfer_ready, xfer_done, xfer_ok;
    logic         xfer_start = 1'b0;
    logic [3:0]   xfer_tag = '0;
    logic [31:0]  xfer_bytes = '0;
    logic         mem_valid, mem_write;
    logic         mem_ready = 1'b0;
    logic [1:0]   mem_kind;
    logic [63:0]  mem_addr;
    logic [31:0]  mem_len, mem_wdata;
    logic         mem_rvalid = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #4 clk = ~clk;

    bdl_dma_engine #(.MAX_ENTRIES(256), .STREAM_IDX(2), .CAPTURE(1'b0)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl_q(ctl_q), .link_pos(link_pos), .xfer_ready(xfer_ready),
        .xfer_start(xfer_start), .xfer_tag(xfer_tag), .xfer_bytes(xfer_bytes),
        .xfer_done(xfer_done), .xfer_ok(xfer_ok), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_kind(mem_kind), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    typedef struct {
        int               kind;
        longint unsigned  addr;
        int unsigned      len;
        bit               wr;
        int unsigned      wdata;
    } txn_t;

    int checks = 0;
    int errors = 0;
    txn_t expq[$];

    longint unsigned d_addr [0:255];
    int unsigned     d_len  [0:255];
    bit              d_ioc  [0:255];
    longint unsigned m_list = 0, m_posb = 0;
    int unsigned     m_ctl = 0, m_cbl = 0, m_lvi = 0, m_bsize = 0;
    int unsigned     m_lpib = 0, m_be = 0, m_bp = 0;
    bit              m_loaded = 0;

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input longint unsigned addr, input int unsigned len,
                        input bit wr, input int unsigned wdata);
        txn_t t;
        t.kind = kind; t.addr = addr; t.len = len; t.wr = wr; t.wdata = wdata;
        expq.push_back(t);
    endtask

    // memory responder: per clock comparison of every handshake against the model queue
    initial begin
        int  cyc = 0;
        bit  due = 0;
        logic [127:0] rsp = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rvalid = 1'b0;
            if (due) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rsp;
                due = 0;
            end
            mem_ready = (cyc % 3) != 1;
            if (!rst && mem_valid && mem_ready) begin
                if (expq.size() == 0) begin
                    check("R11", "unexpected memory request addr", mem_addr, 64'hDEAD);
                end else begin
                    txn_t t;
                    t = expq.pop_front();
                    check(t.kind == KIND_DATA ? "R6" : (t.kind == KIND_POS ? "R10" : "R4"),
                          "mem kind", mem_kind, t.kind);
                    check(t.kind == KIND_DATA ? "R6" : (t.kind == KIND_POS ? "R10" : "R4"),
                          "mem addr", mem_addr, t.addr);
                    check(t.kind == KIND_DATA ? "R6" : (t.kind == KIND_POS ? "R10" : "R4"),
                          "mem len", mem_len, t.len);
                    check("R6", "mem write", mem_write, t.wr);
                    if (t.kind == KIND_POS) check("R10", "pos data", mem_wdata, t.wdata);
                    if (t.kind == KIND_DESC) begin
                        int idx;
                        idx = int'((t.addr - m_list) / 16);
                        rsp = {31'd0, d_ioc[idx], d_len[idx], d_addr[idx]};
                        due = 1;
                    end
                end
            end
        end
    end

    task automatic wr_reg(input reg_sel_e sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            SEL_CTL: begin
                int unsigned n;
                n = (m_ctl & ~CTL_WMASK) | (val & CTL_WMASK);
                n = n & ~(val & CTL_STATUS);
                if (val[0]) n = 0;
                if (!m_ctl[1] && n[1]) begin
                    for (int k = 0; k <= int'(m_lvi); k++)
                        push(KIND_DESC, m_list + 64'(16 * k), 16, 1'b0, 0);
                    m_lpib = 0; m_be = 0; m_bp = 0; m_bsize = m_cbl; m_loaded = 1;
                end
                m_ctl = n;
            end
            SEL_CBL:     m_cbl = val;
            SEL_LVI:     m_lvi = val & 32'hFF;
            SEL_LIST_LO: m_list = {m_list[63:32], val & 32'hFFFF_FF80};
            SEL_POS_LO:  m_posb = {m_posb[63:32], val & 32'hFFFF_FF81};
            default: ;
        endcase
    endtask

    task automatic wait_load();
        int n = 0;
        repeat (3) @(negedge clk);
        while (!xfer_ready && n < 1000) begin @(negedge clk); n++; end
        check("R4", "descriptor reads outstanding", expq.size(), 0);
        check("R4", "link position after load", link_pos, 0);
    endtask

    task automatic do_xfer(input string req, input logic [3:0] tag, input int unsigned bytes);
        bit acc;
        bit irq = 0;
        int n = 0;
        while (!xfer_ready && n < 1000) begin @(negedge clk); n++; end
        acc = m_ctl[1] && m_loaded && !m_ctl[26] && (m_ctl[23:20] == tag);
        if (acc) begin
            int unsigned left = bytes;
            while (left > 0) begin
                int unsigned c = left;
                if (m_bsize - m_lpib < c) c = m_bsize - m_lpib;
                if (d_len[m_be] - m_bp < c) c = d_len[m_be] - m_bp;
                push(KIND_DATA, d_addr[m_be] + 64'(m_bp), c, 1'b0, 0);
                m_lpib += c; m_bp += c; left -= c;
                if (m_lpib == m_bsize) m_lpib = 0;
                if (m_bp == d_len[m_be]) begin
                    if (d_ioc[m_be]) irq = 1;
                    m_bp = 0;
                    if (m_be == m_lvi) begin m_be = 0; m_lpib = 0; end
                    else m_be++;
                end
            end
            if (m_posb[0]) push(KIND_POS, (m_posb & ~64'd1) + 64'd16, 4, 1'b1, m_lpib);
            if (irq) m_ctl[26] = 1'b1;
        end
        @(negedge clk);
        xfer_start = 1'b1; xfer_tag = tag; xfer_bytes = bytes;
        @(negedge clk);
        xfer_start = 1'b0;
        n = 0;
        while (!xfer_done && n < 5000) begin @(negedge clk); n++; end
        check(req, "transfer completed", xfer_done, 1);
        check(req, "xfer_ok", xfer_ok, acc);
        check(req, "link_pos", link_pos, m_lpib);
        check(req, "completion bit", ctl_q[26], m_ctl[26]);
        check(req, "memory requests left", expq.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        d_addr[0] = 64'h8000; d_len[0] = 200; d_ioc[0] = 0;
        d_addr[1] = 64'h9000; d_len[1] = 300; d_ioc[1] = 1;
        d_addr[2] = 64'hA000; d_len[2] = 100; d_ioc[2] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "ctl after reset", ctl_q, 0);
        check("R1", "link_pos after reset", link_pos, 0);
        check("R1", "mem_valid after reset", mem_valid, 0);
        check("R1", "xfer_ready after reset", xfer_ready, 1);

        // R2 write mask
        wr_reg(SEL_CTL, 32'hFFFF_FFFC);
        check("R2", "masked control", ctl_q, 32'h00FF_001C);
        wr_reg(SEL_CTL, 32'h0);
        check("R2", "control cleared by plain write", ctl_q, 0);

        wr_reg(SEL_CBL, 600);
        wr_reg(SEL_LVI, 2);
        wr_reg(SEL_LIST_LO, 32'h1000);
        wr_reg(SEL_LIST_HI, 0);
        wr_reg(SEL_CTL, 32'h0050_0002);
        wait_load();
        check("R4", "control after run", ctl_q, 32'h0050_0002);

        do_xfer("R5", 4'd3, 150);          // wrong tag refused
        do_xfer("R6", 4'd5, 150);          // single chunk
        do_xfer("R7", 4'd5, 100);          // crosses into entry 1
        do_xfer("R9", 4'd5, 260);          // consumes flagged entry 1
        check("R9", "completion set", ctl_q[26], 1);
        do_xfer("R5", 4'd5, 10);           // refused while completion pending

        wr_reg(SEL_CTL, 32'h0050_0002);
        check("R2", "status kept on write of 0", ctl_q, 32'h0450_0002);
        wr_reg(SEL_CTL, 32'h0450_0002);
        check("R2", "status cleared by write of 1", ctl_q, 32'h0050_0002);
        check("R4", "no reload without run edge", expq.size(), 0);

        wr_reg(SEL_POS_LO, 32'h3001);
        wr_reg(SEL_POS_HI, 0);
        do_xfer("R10", 4'd5, 120);         // wraps list and writes position
        check("R7", "position after list wrap", link_pos, 30);

        // smaller cyclic buffer: clip at buffer end
        wr_reg(SEL_CTL, 32'h0050_0000);
        wr_reg(SEL_POS_LO, 0);
        wr_reg(SEL_CBL, 250);
        wr_reg(SEL_LVI, 1);
        wr_reg(SEL_CTL, 32'h0050_0002);
        wait_load();
        do_xfer("R6", 4'd5, 220);
        do_xfer("R8", 4'd5, 60);
        check("R8", "position after buffer wrap", link_pos, 30);

        // R3 stream reset
        wr_reg(SEL_CTL, 32'h0050_0003);
        check("R3", "control after stream reset", ctl_q, 0);
        do_xfer("R5", 4'd0, 40);           // run clear: refused

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule